// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Burst Line Fill

This block sits between an instruction fetch unit and a memory bus that can return bursts. Every instruction is a word-aligned 32-bit word. The cache keeps sixteen lines, and each line holds four words, which is also the longest burst the bus can return. A fetch that finds its line present and tagged for its address gets its word one cycle after the fetch is accepted. A fetch that misses raises a one-cycle burst request for the whole line. The four returned words are then written into the line in ascending order.

The missed word does not wait for the fill to finish. It is handed to the fetch side in the same cycle its beat comes back from the bus, while that beat is also written into the array. The line becomes valid only once its last beat has been written. The fetch port stays closed for the whole refill, so a later fetch can never see a half-filled line.

Top module: `fetch_line_cache`

## Requirements
- R1: Fetch address bits [1:0] are ignored. An address with nonzero low bits returns the same word, with the same hit or miss outcome, as the address with those bits cleared.
- R2: Reset invalidates every line, so the first fetch to any address after reset is a miss.
- R3: A fetch accepted (fetchValid and fetchReady both high at a clock edge) that hits produces respValid with the cached word in the next cycle. That cycle has no memReq, and fetchReady stays high.
- R4: A fetch that misses raises memReq for exactly one cycle, in the cycle after acceptance. memAddr then carries the line base, which is the fetch address with bits [3:0] cleared.
- R5: The four beats of a burst are written to words 0, 1, 2 and 3 of the line, in that order. After the fill, fetches to any of the four words hit and return the bus data of that word.
- R6: On a miss, respValid rises combinationally in the cycle whose memBeatValid carries the requested word, which is word number fetchAddr[3:2]. respData equals memBeatData in that cycle. In the other beat cycles of the fill, respValid stays low.
- R7: fetchReady is low from the cycle after a miss is accepted through the cycle of the fourth beat. It is high again in the following cycle.
- R8: The mapping is direct. Line index is fetchAddr[7:4] and tag is fetchAddr[31:8]. A fetch whose tag differs from the stored tag at its index misses and replaces that line, so the old address misses afterwards.
- R9: Every accepted fetch produces exactly one response, and responses come back in fetch order.
- R10: Cycles without memBeatValid during a fill stall it. No beat is counted, and no response is produced until the requested beat arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | Fetch request present |
| fetchAddr | input | 32 | Byte address of the instruction |
| fetchReady | output | 1 | Cache can accept a fetch this cycle |
| respValid | output | 1 | Instruction word valid |
| respData | output | 32 | Instruction word |
| memReq | output | 1 | One-cycle burst read request |
| memAddr | output | 32 | Line base address of the burst |
| memBeatValid | input | 1 | Burst beat present this cycle |
| memBeatData | input | 32 | Burst beat data |

## Verification
Directed fetches walk one line: a cold miss on word 0, then hits on words 1 to 3, then a hit through an address with nonzero low bits. Together these separate correct word placement from a fill that rotates or repeats beats. Misses on word 3 under varied beat gaps show that forwarding follows the beat counter and not elapsed time. A fetch to the same index with a different tag shows that the tag compare, not just the valid bit, decides a hit. A mid-run reset followed by a repeat fetch shows that valid bits really clear. A long mixed run over four tags and four indices, with random gap patterns, checks response order and data against an independent tag model.

// File: rtl/fetch_line_cache_pkg.sv
package fetch_line_cache_pkg;

  typedef enum logic [1:0] {
    CTRL_IDLE  = 2'd0,
    CTRL_ISSUE = 2'd1,
    CTRL_FILL  = 2'd2
  } ctrlState_e;

  typedef struct packed {
    logic latchReq;
    logic captureHit;
    logic fillWrite;
    logic lineCommit;
  } ctrlStrobe_t;

endpackage

// File: rtl/fetch_line_cache_datapath.sv
module fetch_line_cache_datapath
  import fetch_line_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  localparam int BYTE_BITS = $clog2(DATA_W / 8),
  localparam int WORD_BITS = $clog2(WORDS),
  localparam int IDX_BITS  = $clog2(LINES),
  localparam int OFF_BITS  = BYTE_BITS + WORD_BITS,
  localparam int TAG_LO    = OFF_BITS + IDX_BITS,
  localparam int TAG_BITS  = ADDR_W - TAG_LO
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [ADDR_W-1:0]    fetchAddr,
  input  logic [DATA_W-1:0]    memBeatData,
  input  logic [WORD_BITS-1:0] beatIdx,
  output logic                 hit,
  output logic [WORD_BITS-1:0] reqWord,
  output logic [ADDR_W-1:0]    lineBase,
  output logic [DATA_W-1:0]    hitData
);

  logic [ADDR_W-1:0]   reqAddrQ;
  logic [LINES-1:0]    validQ;
  logic [TAG_BITS-1:0] tagMem  [LINES];
  logic [DATA_W-1:0]   dataMem [LINES][WORDS];

  logic [IDX_BITS-1:0]  lookIdx;
  logic [TAG_BITS-1:0]  lookTag;
  logic [WORD_BITS-1:0] lookWord;
  logic [IDX_BITS-1:0]  fillIdx;
  logic [TAG_BITS-1:0]  fillTag;
  logic                 unusedByteBits;

  assign lookIdx  = fetchAddr[OFF_BITS +: IDX_BITS];
  assign lookTag  = fetchAddr[TAG_LO +: TAG_BITS];
  assign lookWord = fetchAddr[BYTE_BITS +: WORD_BITS];
  assign fillIdx  = reqAddrQ[OFF_BITS +: IDX_BITS];
  assign fillTag  = reqAddrQ[TAG_LO +: TAG_BITS];
  assign reqWord  = reqAddrQ[BYTE_BITS +: WORD_BITS];
  assign lineBase = {reqAddrQ[ADDR_W-1:OFF_BITS], {OFF_BITS{1'b0}}};
  assign unusedByteBits = ^{fetchAddr[BYTE_BITS-1:0], reqAddrQ[BYTE_BITS-1:0]};

  assign hit = validQ[lookIdx] && (tagMem[lookIdx] == lookTag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddrQ <= '0;
      hitData  <= '0;
    end else begin
      if (strobe.latchReq)   reqAddrQ <= fetchAddr;
      if (strobe.captureHit) hitData  <= dataMem[lookIdx][lookWord];
    end
  end

  for (genvar gl = 0; gl < LINES; gl++) begin : g_line
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[gl] <= 1'b0;
        tagMem[gl] <= '0;
      end else if (strobe.lineCommit && (fillIdx == IDX_BITS'(gl))) begin
        validQ[gl] <= 1'b1;
        tagMem[gl] <= fillTag;
      end
    end
    for (genvar gw = 0; gw < WORDS; gw++) begin : g_word
      always_ff @(posedge clk) begin
        if (strobe.fillWrite && (fillIdx == IDX_BITS'(gl)) && (beatIdx == WORD_BITS'(gw)))
          dataMem[gl][gw] <= memBeatData;
      end
    end
  end

  // A line only turns valid together with the write of its final beat.
  assert_commit_last_beat_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lineCommit |-> (strobe.fillWrite && beatIdx == WORD_BITS'(WORDS - 1)));

  // A hit capture and a fill write never share a cycle.
  assert_no_capture_in_fill_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillWrite |-> !strobe.captureHit);

endmodule

// File: rtl/fetch_line_cache_ctrl.sv
module fetch_line_cache_ctrl
  import fetch_line_cache_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int WORD_BITS = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fetchValid,
  input  logic                 hit,
  input  logic                 memBeatValid,
  input  logic [WORD_BITS-1:0] reqWord,
  output ctrlStrobe_t          strobe,
  output logic                 fetchReady,
  output logic                 memReq,
  output logic [WORD_BITS-1:0] beatIdx,
  output logic                 respValid,
  output logic                 fwdSel
);

  ctrlState_e           stateQ, stateD;
  logic [WORD_BITS-1:0] beatCntQ;
  logic                 hitRespQ;
  logic                 accept;
  logic                 lastBeat;

  assign fetchReady = (stateQ == CTRL_IDLE);
  assign accept     = fetchValid && fetchReady;
  assign memReq     = (stateQ == CTRL_ISSUE);
  assign beatIdx    = beatCntQ;
  assign lastBeat   = (beatCntQ == WORD_BITS'(WORDS - 1));
  assign fwdSel     = (stateQ == CTRL_FILL) && memBeatValid && (beatCntQ == reqWord);
  assign respValid  = hitRespQ || fwdSel;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      CTRL_IDLE: begin
        if (accept) begin
          strobe.latchReq = 1'b1;
          if (hit) strobe.captureHit = 1'b1;
          else     stateD = CTRL_ISSUE;
        end
      end
      CTRL_ISSUE: stateD = CTRL_FILL;
      CTRL_FILL: begin
        if (memBeatValid) begin
          strobe.fillWrite = 1'b1;
          if (lastBeat) begin
            strobe.lineCommit = 1'b1;
            stateD = CTRL_IDLE;
          end
        end
      end
      default: stateD = CTRL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= CTRL_IDLE;
      beatCntQ <= '0;
      hitRespQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      hitRespQ <= accept && hit;
      if (stateQ == CTRL_ISSUE)
        beatCntQ <= '0;
      else if (strobe.fillWrite)
        beatCntQ <= beatCntQ + WORD_BITS'(1);
    end
  end

  // Burst request is a single-cycle pulse.
  assert_single_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // Once a burst is requested the fetch port stays closed.
  assert_ready_low_after_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !fetchReady);

  // A missed fetch is followed by its burst request.
  assert_miss_issues_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !hit) |=> memReq);

  // Stall cycles leave the beat counter alone.
  assert_gap_holds_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == CTRL_FILL) && !memBeatValid) |=> $stable(beatCntQ));

endmodule

// File: rtl/fetch_line_cache.sv
module fetch_line_cache
  import fetch_line_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  localparam int WORD_BITS = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchReady,
  output logic              respValid,
  output logic [DATA_W-1:0] respData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memBeatValid,
  input  logic [DATA_W-1:0] memBeatData
);

  ctrlStrobe_t          strobe;
  logic                 hit;
  logic                 fwdSel;
  logic [WORD_BITS-1:0] reqWord;
  logic [WORD_BITS-1:0] beatIdx;
  logic [DATA_W-1:0]    hitData;

  fetch_line_cache_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk, .rstN, .fetchValid, .hit, .memBeatValid, .reqWord,
    .strobe, .fetchReady, .memReq, .beatIdx, .respValid, .fwdSel
  );

  fetch_line_cache_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)
  ) u_dp (
    .clk, .rstN, .strobe, .fetchAddr, .memBeatData, .beatIdx,
    .hit, .reqWord, .lineBase(memAddr), .hitData
  );

  assign respData = fwdSel ? memBeatData : hitData;

  // Accepted hit answers in the next cycle.
  assert_hit_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchReady && hit) |=> (respValid && !memReq));

  // Forwarded word comes straight from the bus beat.
  assert_forward_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !fetchReady) |-> (memBeatValid && respData == memBeatData));

endmodule

// File: tb/fetch_line_cache_tb.sv
module fetch_line_cache_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        fetchValid;
  logic [31:0] fetchAddr;
  logic        fetchReady;
  logic        respValid;
  logic [31:0] respData;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memBeatValid;
  logic [31:0] memBeatData;

  always #5 clk = ~clk;

  fetch_line_cache u_dut (
    .clk, .rstN, .fetchValid, .fetchAddr, .fetchReady, .respValid, .respData,
    .memReq, .memAddr, .memBeatValid, .memBeatData
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        mValid[16];
  logic [23:0] mTag[16];
  int          fwdWord = 0;
  logic [31:0] expBase = '0;
  int          gapMode = 0;

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:2], 2'b01, ~a[15:2], 2'b10} ^ 32'h3C5A_96E1;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // monitor: pops the scoreboard whenever a response appears
  initial begin
    forever begin
      logic [31:0] e;
      string       t;
      @(negedge clk); #4;
      if (rstN === 1'b1 && respValid) begin
        if (expQ.size() == 0) check(0, "R9 unexpected response", respData, 32'h0);
        else begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(respData == e, {"R9 data ", t}, respData, e);
        end
      end
    end
  end

  // memory model: answers each burst request with gapped beats
  initial begin
    memBeatValid = 1'b0;
    memBeatData  = '0;
    forever begin
      logic [31:0] base;
      @(negedge clk); #4;
      if (rstN === 1'b1 && memReq) begin
        base = memAddr;
        check(base == expBase, "R4 burst line base", base, expBase);
        for (int b = 0; b < 4; b++) begin
          repeat ((gapMode >> (2 * b)) & 3) begin
            @(negedge clk); memBeatValid = 1'b0; #4;
            check(!respValid, "R10 no response in gap", respValid, 0);
            check(!fetchReady, "R7 ready low in gap", fetchReady, 0);
          end
          @(negedge clk);
          memBeatValid = 1'b1;
          memBeatData  = memWord(base + 32'(4 * b));
          #4;
          check(respValid == (b == fwdWord), "R6 forward on requested beat", respValid, (b == fwdWord));
          check(!fetchReady, "R7 ready low during beat", fetchReady, 0);
        end
        @(negedge clk); memBeatValid = 1'b0; #4;
        check(fetchReady, "R7 ready after fourth beat", fetchReady, 1);
      end
    end
  end

  task automatic doFetch(input logic [31:0] a, input string t);
    bit hit;
    logic [3:0]  idx;
    logic [23:0] tg;
    idx = a[7:4];
    tg  = a[31:8];
    @(negedge clk);
    fetchValid = 1'b1;
    fetchAddr  = a;
    #4;
    while (!fetchReady) begin @(negedge clk); #4; end
    hit = mValid[idx] && mTag[idx] == tg;
    expQ.push_back(memWord({a[31:2], 2'b00}));
    tagQ.push_back(t);
    if (!hit) begin
      fwdWord = int'(a[3:2]);
      expBase = {a[31:4], 4'h0};
      mValid[idx] = 1'b1;
      mTag[idx]   = tg;
    end
    @(negedge clk);
    fetchValid = 1'b0;
    #4;
    if (hit) begin
      check(!memReq, {"R3 no burst on hit ", t}, memReq, 0);
      check(respValid, {"R3 hit latency ", t}, respValid, 1);
      check(fetchReady, "R3 ready stays high", fetchReady, 1);
    end else begin
      check(memReq, {"R4 burst on miss ", t}, memReq, 1);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    fetchValid = 1'b0;
    fetchAddr  = '0;
    for (int i = 0; i < 16; i++) mValid[i] = 1'b0;
    repeat (3) @(negedge clk);
    #4;
    check(!respValid, "R2 no response in reset", respValid, 0);
    check(!memReq, "R2 no request in reset", memReq, 0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    summary();
    $finish;
  end

  initial begin
    doReset();
    check(fetchReady, "R2 ready after reset", fetchReady, 1);
    gapMode = 0;
    doFetch(32'h0000_0100, "R2 cold miss");
    doFetch(32'h0000_0104, "R5 word1");
    doFetch(32'h0000_0108, "R5 word2");
    doFetch(32'h0000_010C, "R5 word3");
    doFetch(32'h0000_010E, "R1 low bits ignored");
    doFetch(32'h0000_0101, "R1 low bits word0");
    gapMode = 8'b10_01_11_01;
    doFetch(32'h0000_020C, "R6 word3 gapped");
    doFetch(32'h0000_0204, "R5 gapped fill word1");
    gapMode = 8'b00_11_00_10;
    doFetch(32'h0000_1108, "R8 conflict miss");
    doFetch(32'h0000_0100, "R8 evicted miss");
    doFetch(32'h0000_0104, "R8 refill hit");
    repeat (3) @(negedge clk);
    doReset();
    doFetch(32'h0000_0104, "R2 miss after reset");
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a;
      a = 32'((($urandom % 4) << 8) | (($urandom % 4) << 4) | (($urandom % 4) << 2) | ($urandom % 4));
      gapMode = int'($urandom % 256);
      doFetch(a, "R9 mixed");
    end
    repeat (12) @(negedge clk);
    #4;
    check(expQ.size() == 0, "R9 all responses returned", 32'(expQ.size()), 32'h0);
    summary();
    $finish;
  end

endmodule